// File: doc/BRIEF.md
# Multi-Mode Step Clock Generator

This block makes the step clock for an array of programmable flip-flops. It runs from one fast system clock. Its output is a clock-enable pulse, `tick`, that is exactly one system cycle wide. The flip-flop array advances on each pulse.

A two-bit mode input picks the source of the pulses. In free-running mode, a prescaler makes one of seven fixed rates. In single-step mode, each debounced press of a manual contact makes one pulse. In external mode, each falling edge of a trigger line makes one pulse. In parallel mode, each positive pulse from another unit makes one pulse, so several units can step together. Every pulse made is also repeated on `par_out`, so other units can follow this one. An active-high inhibit line blocks every pulse in every mode.

The trigger, contact, parallel input and inhibit are asynchronous. Each one passes through a two-flop synchronizer before its edges are detected. The mode and rate selectors are synchronous to the system clock.

Top module: `step_clock_gen`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `tick` and `par_out` are low.
- R2: In free-running mode (mode 0), the rate code picks the frequency:
  - 0 = 1 Hz, 1 = 2 Hz, 2 = 5 Hz, 3 = 50 Hz,
  - 4 = 100 Hz, 5 = 1 kHz, 6 = 10 kHz.

  Consecutive pulses are exactly SYS_HZ/f system cycles apart.
- R3: In mode 0 with rate code 7, no pulse is ever made.
- R4: Any change of mode or rate restarts the divider, with no pulse in the cycle after the change. In free-running mode, the first pulse comes exactly SYS_HZ/f cycles after the first clock edge that sees the new selection.
- R5: The mode codes are 0 free-running, 1 single-step, 2 external trigger and 3 parallel input. The inputs that belong to modes other than the selected one have no effect on `tick`.
- R6: In mode 2, each 1-to-0 transition of `trig` makes exactly one pulse. A 0-to-1 transition makes none.
- R7: In mode 1, `step_n` is active low.
  - A press counts only after the synchronized contact has held its new level for DEB_CYCLES consecutive cycles.
  - A shorter glitch is ignored.
  - Each accepted press makes one pulse. A release makes none.
- R8: In mode 3, each 0-to-1 transition of `par_in` makes exactly one pulse.
- R9: While `inhibit` is 1, no pulse is made. Edges that arrive during inhibit are dropped, not held for later.
- R10: Each pulse is one system cycle wide, and `par_out` is high in exactly the cycles in which `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Clock source select (0 free, 1 single-step, 2 external, 3 parallel) |
| rate | input | 3 | Free-running rate code (0..6), 7 = off |
| inhibit | input | 1 | Asynchronous; 1 blocks all pulses |
| step_n | input | 1 | Asynchronous manual contact, low when closed |
| trig | input | 1 | Asynchronous external trigger, falling edge counts |
| par_in | input | 1 | Asynchronous clock pulses from another unit |
| tick | output | 1 | One-cycle step clock enable |
| par_out | output | 1 | Repeat of `tick` for slaved units |

## Verification
The bench builds the block with SYS_HZ = 20000 and DEB_CYCLES = 4. With these values, even the 1 Hz divider finishes a full period in 20000 cycles. Every rate can therefore be timed to the exact cycle, both from a selection change to the first pulse and across a pulse-count window. The short debounce count lets the bench tell a two-cycle glitch from a real press, and a bounced press from a clean one, in only a few cycles.

// File: rtl/step_clock_gen.sv
module step_clock_gen #(
  parameter int SYS_HZ     = 50_000_000,
  parameter int DEB_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [2:0] rate,
  input  logic       inhibit,
  input  logic       step_n,
  input  logic       trig,
  input  logic       par_in,
  output logic       tick,
  output logic       par_out
);
  localparam int CW = $clog2(SYS_HZ + 1);
  localparam int DW = $clog2(DEB_CYCLES + 1);
  localparam logic [1:0] M_FREE = 2'd0, M_STEP = 2'd1, M_EXT = 2'd2;

  function automatic logic [CW-1:0] period(input logic [2:0] r);
    case (r)
      3'd0:    return CW'(SYS_HZ);
      3'd1:    return CW'(SYS_HZ / 2);
      3'd2:    return CW'(SYS_HZ / 5);
      3'd3:    return CW'(SYS_HZ / 50);
      3'd4:    return CW'(SYS_HZ / 100);
      3'd5:    return CW'(SYS_HZ / 1000);
      3'd6:    return CW'(SYS_HZ / 10000);
      default: return '0;
    endcase
  endfunction

  logic [4:0]    sel_q;
  logic [1:0]    inh_sy, step_sy;
  logic [2:0]    trig_sy, par_sy;
  logic [CW-1:0] cnt;
  logic [DW-1:0] deb_cnt;
  logic          deb_lvl;
  logic          fire;

  wire [CW-1:0] div      = period(rate);
  wire          chg      = {mode, rate} != sel_q;
  wire          inh      = inh_sy[1];
  wire          t_fall   = trig_sy[2] & ~trig_sy[1];
  wire          p_rise   = par_sy[1] & ~par_sy[2];
  wire          deb_flip = (step_sy[1] != deb_lvl) && (deb_cnt == DW'(DEB_CYCLES - 1));
  wire          press    = deb_flip & deb_lvl;
  wire          wrap     = (div != '0) && (cnt == div - CW'(1));

  always_comb begin
    case (mode)
      M_FREE:  fire = wrap;
      M_STEP:  fire = press;
      M_EXT:   fire = t_fall;
      default: fire = p_rise;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      inh_sy  <= '0;
      step_sy <= '1;
      trig_sy <= '1;
      par_sy  <= '0;
      cnt     <= '0;
      deb_cnt <= '0;
      deb_lvl <= 1'b1;
      tick    <= 1'b0;
    end else begin
      sel_q   <= {mode, rate};
      inh_sy  <= {inh_sy[0], inhibit};
      step_sy <= {step_sy[0], step_n};
      trig_sy <= {trig_sy[1:0], trig};
      par_sy  <= {par_sy[1:0], par_in};

      if (chg || inh || mode != M_FREE || div == '0 || wrap) cnt <= '0;
      else cnt <= cnt + CW'(1);

      if (step_sy[1] == deb_lvl) deb_cnt <= '0;
      else if (deb_flip) begin
        deb_lvl <= step_sy[1];
        deb_cnt <= '0;
      end else deb_cnt <= deb_cnt + DW'(1);

      tick <= fire & ~inh & ~chg;
    end
  end

  assign par_out = tick;
endmodule

// File: rtl/step_clock_gen_chk.sv
module step_clock_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [2:0] rate,
  input logic       inhibit,
  input logic       tick
);
  assert_one_wide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("R10: tick wider than one cycle");

  assert_inhibit_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && $past(inhibit) && $past(inhibit, 2) && $past(inhibit, 3)) |-> !tick)
    else $error("R9: tick while inhibited");

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mode, rate}) |=> !tick) else $error("R4: tick right after selection change");

  assert_rate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && rate == 3'd7) |=> !tick) else $error("R3: tick with rate code 7");
endmodule

bind step_clock_gen step_clock_gen_chk u_chk (.*);

// File: tb/step_clock_gen_test.sv
module step_clock_gen_test;
  localparam int SYS_HZ = 20000;
  localparam int DEB    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] rate = 3'd7;
  logic inhibit = 1'b0, step_n = 1'b1, trig = 1'b1, par_in = 1'b0;
  logic tick, par_out;

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  int win_t = 0, win_p = 0;
  bit win_open = 0;
  bit finished = 0;
  event done;

  step_clock_gen #(.SYS_HZ(SYS_HZ), .DEB_CYCLES(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate(rate), .inhibit(inhibit),
    .step_n(step_n), .trig(trig), .par_in(par_in), .tick(tick), .par_out(par_out));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #3; end
  endtask

  task automatic open_win(int exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    win_t = 0;
    win_p = 0;
    win_open = 1;
  endtask

  task automatic close_win();
    win_open = 0;
    ->done;
    #1;
  endtask

  always @(negedge clk) if (win_open) begin
    if (tick) win_t++;
    if (par_out) win_p++;
  end

  always @(done) begin
    int e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(t, win_t, e);
    chk({t, "/R10 par_out"}, win_p, e);
  end

  function automatic int per(int r);
    int f[7] = '{1, 2, 5, 50, 100, 1000, 10000};
    return SYS_HZ / f[r];
  endfunction

  task automatic run_rate(int r, int k);
    int d, steps;
    bit early;
    d = per(r);
    rate = 3'(r);
    mode = 2'd0;
    steps = 0;
    early = 0;
    cyc(1);
    steps = 1;
    chk("R4 no tick after change", int'(tick), 0);
    while (!tick && steps < d + 5) begin
      cyc(1);
      steps++;
    end
    chk($sformatf("R4 first tick delay rate %0d", r), steps, d + 1);
    cyc(1);
    open_win(k, $sformatf("R2 count rate %0d", r));
    cyc(k * d);
    close_win();
  endtask

  initial begin
    cyc(3);
    chk("R1 tick in reset", int'(tick), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 tick after reset", int'(tick), 0);
    chk("R1 par_out after reset", int'(par_out), 0);

    run_rate(0, 1);
    run_rate(1, 2);
    run_rate(2, 3);
    for (int r = 3; r < 7; r++) run_rate(r, 5);
    cyc(150);
    run_rate(4, 3);

    rate = 3'd7;
    cyc(2);
    open_win(0, "R3 rate 7 silent, R5 foreign inputs");
    trig = 1'b0; cyc(4); trig = 1'b1; cyc(4);
    par_in = 1'b1; cyc(4); par_in = 1'b0; cyc(4);
    step_n = 1'b0; cyc(12); step_n = 1'b1; cyc(12);
    cyc(400);
    close_win();

    mode = 2'd2;
    cyc(4);
    open_win(3, "R6 falling edges");
    for (int i = 0; i < 3; i++) begin
      trig = 1'b0; cyc(3); trig = 1'b1; cyc(3);
    end
    cyc(4);
    close_win();
    trig = 1'b0;
    cyc(6);
    open_win(0, "R6 rising edge");
    trig = 1'b1;
    cyc(6);
    close_win();
    open_win(0, "R5 par_in in external mode");
    par_in = 1'b1; cyc(3); par_in = 1'b0; cyc(6);
    close_win();

    mode = 2'd1;
    cyc(4);
    open_win(0, "R7 glitch");
    step_n = 1'b0; cyc(2); step_n = 1'b1; cyc(10);
    close_win();
    open_win(1, "R7 bounced press");
    step_n = 1'b0; cyc(1); step_n = 1'b1; cyc(1); step_n = 1'b0; cyc(14);
    close_win();
    open_win(0, "R7 release");
    step_n = 1'b1; cyc(14);
    close_win();

    mode = 2'd3;
    cyc(4);
    open_win(4, "R8 parallel pulses");
    for (int i = 0; i < 4; i++) begin
      par_in = 1'b1; cyc(3); par_in = 1'b0; cyc(3);
    end
    cyc(4);
    close_win();

    mode = 2'd0;
    rate = 3'd6;
    inhibit = 1'b1;
    cyc(4);
    open_win(0, "R9 inhibit free-running");
    cyc(40);
    close_win();
    mode = 2'd2;
    cyc(2);
    open_win(0, "R9 inhibit external");
    trig = 1'b0; cyc(3); trig = 1'b1; cyc(3);
    close_win();
    inhibit = 1'b0;
    cyc(4);
    open_win(0, "R9 dropped, not held");
    cyc(10);
    close_win();
    open_win(1, "R9 edge after release");
    trig = 1'b0; cyc(6); trig = 1'b1; cyc(3);
    close_win();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule